// File: doc/BRIEF.md
# Polyphase Wavelet Analysis Filter Unit

This unit produces one decimated wavelet output, low band or high band, for every pair of input samples. The filter has an even number of taps L. Its multiply-accumulate work is split into two independent halves that run side by side. The even half sees only the even-indexed samples of the padded input and the odd half sees only the odd-indexed samples, so each half holds L/2 product terms. A separate pipelined stage adds the two half sums in a carry-propagate adder. Because the filter decimates by two, each output moves the window forward by one position in each half.

A feeder delivers the signal as a stream of sample pairs (even sample, odd sample), with a valid strobe and a band select. The high band uses the same coefficient set as the low band. It only inverts the sign of the even-half products, so one set of coefficients serves both outputs. To extend a finite frame periodically, the feeder appends the first L−2 samples of the frame after its last sample. A frame of N samples then yields exactly N/2 outputs once the window has filled. The unit holds no frame state of its own. The default build uses six taps with 8-bit signed samples and 8-bit signed coefficients. The output is full precision.

Top module: `dwt_split_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and out_data is 0.
- R2: out_valid is 1 in exactly those cycles that follow, by two rising clock edges, a cycle in which in_valid was sampled at 1.
- R3: With hp_sel = 0, the result for the pair accepted as the k-th pair since reset (pairs numbered from 0) is sum over i of c[i]·x[2(k−L/2+1)+i]. Here x[2m] and x[2m+1] are the even and odd samples of pair m, and tap i occupies coef_flat[i·CW +: CW]. Even taps i multiply even samples and odd taps multiply odd samples.
- R4: With hp_sel = 1, the result is the R3 sum with every even-tap product negated and every odd-tap product unchanged.
- R5: A cycle with in_valid = 0 does not move the sample window. The next valid pair is combined with the same earlier pairs as if the idle cycle had not occurred.
- R6: In a cycle where out_valid is 0, out_data keeps the value it had in the previous cycle.
- R7: After reset the window history is zero, so samples of pairs numbered below 0 contribute nothing to the sums of R3 and R4.
- R8: When a frame of N samples is followed by its own first L−2 samples, the outputs from pairs L/2−1 through N/2+L/2−2 equal the periodically extended analysis result y[k] = sum c[i]·f[(2k+i) mod N]. That is N/2 outputs, and the last one combines the tail of the frame with its head.
- R9: The output is two's complement, SW+CW+ceil(log2 L) bits wide, and exact for all input and coefficient values, including every sample and coefficient at the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is present this cycle |
| in_even | input | SW | Even-indexed sample, signed |
| in_odd | input | SW | Odd-indexed sample, signed |
| hp_sel | input | 1 | 0 selects the low band, 1 the high band |
| coef_flat | input | TAPS·CW | Signed coefficients, tap i at bits i·CW +: CW |
| out_valid | output | 1 | out_data carries a new result |
| out_data | output | SW+CW+ceil(log2 TAPS) | Filter result, signed |

## Verification
The stimulus table mixes positive and negative samples, alternates bands from one pair to the next, and inserts idle gaps. An error that swaps the even and odd halves, negates the wrong half, or shifts the window during idle cycles therefore changes a compared value. A pair sent straight after reset isolates the newest taps against the cleared history. A stream in which every sample and coefficient sits at the most negative value would expose any truncation of the accumulator. A 16-sample frame followed by its first four samples is compared against a direct circular-convolution model, which checks both the wrap-around output and the exact output count.

// File: rtl/dwt_split_pkg.sv
package dwt_split_pkg;
  typedef enum logic {
    BAND_LOW  = 1'b0,
    BAND_HIGH = 1'b1
  } band_e;

  typedef enum int {
    LANE_EVEN = 0,
    LANE_ODD  = 1
  } lane_e;
endpackage

// File: rtl/dwt_tap_window.sv
module dwt_tap_window #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps
);
  // taps[DEPTH-1] is the incoming sample, lower indices are older samples
  logic [DEPTH-2:0][W-1:0] hist;

  always_comb begin
    taps[DEPTH-1] = din;
    for (int j = 0; j < DEPTH-1; j++) taps[j] = hist[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (shift) begin
      for (int j = 0; j < DEPTH-1; j++) hist[j] <= taps[j+1];
    end
  end

  // R5: an idle cycle leaves the history untouched
  assert_window_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(hist));
endmodule

// File: rtl/dwt_half_mac.sv
module dwt_half_mac #(
  parameter int SW = 8,
  parameter int CW = 8,
  parameter int OW = 19,
  parameter int N  = 3
) (
  input  logic [N-1:0][SW-1:0] samp,
  input  logic [N-1:0][CW-1:0] cf,
  input  logic                 neg,
  output logic signed [OW-1:0] psum
);
  function automatic logic signed [OW-1:0] tap_product(
    input logic signed [SW-1:0] s,
    input logic signed [CW-1:0] c
  );
    logic signed [OW-1:0] se;
    logic signed [OW-1:0] ce;
    se = OW'(s);
    ce = OW'(c);
    return se * ce;
  endfunction

  always_comb begin
    logic signed [OW-1:0] acc;
    logic signed [OW-1:0] term;
    acc = '0;
    for (int j = 0; j < N; j++) begin
      term = tap_product(signed'(samp[j]), signed'(cf[j]));
      acc  = neg ? (acc - term) : (acc + term);
    end
    psum = acc;
  end
endmodule

// File: rtl/dwt_sum_stage.sv
module dwt_sum_stage #(
  parameter int OW = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [OW-1:0] ev_sum,
  input  logic signed [OW-1:0] od_sum,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  logic signed [OW-1:0] ev_q;
  logic signed [OW-1:0] od_q;
  logic                 v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q      <= '0;
      od_q      <= '0;
      v_q       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      v_q       <= in_valid;
      out_valid <= v_q;
      if (in_valid) begin
        ev_q <= ev_sum;
        od_q <= od_sum;
      end
      if (v_q) out_data <= ev_q + od_q;
    end
  end

  // R2: half sums registered one edge after acceptance
  assert_stage_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v_q);
  // R6: no new result means the output word is held
  assert_output_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |=> (!out_valid && $stable(out_data)));
endmodule

// File: rtl/dwt_split_filter.sv
module dwt_split_filter
  import dwt_split_pkg::*;
#(
  parameter int SW   = 8,
  parameter int CW   = 8,
  parameter int TAPS = 6,
  localparam int HALF = TAPS / 2,
  localparam int OW   = SW + CW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SW-1:0]        in_even,
  input  logic [SW-1:0]        in_odd,
  input  logic                 hp_sel,
  input  logic [TAPS*CW-1:0]   coef_flat,
  output logic                 out_valid,
  output logic [OW-1:0]        out_data
);
  band_e band;
  assign band = band_e'(hp_sel);

  logic [HALF-1:0][SW-1:0] lane_taps [2];
  logic [HALF-1:0][CW-1:0] lane_cf   [2];
  logic signed [OW-1:0]    lane_sum  [2];
  logic signed [OW-1:0]    sum_out;

  // tap i = 2j+lane goes to position j of that lane
  always_comb begin
    for (int j = 0; j < HALF; j++) begin
      lane_cf[LANE_EVEN][j] = coef_flat[(2*j)*CW +: CW];
      lane_cf[LANE_ODD][j]  = coef_flat[(2*j+1)*CW +: CW];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dwt_tap_window #(.W(SW), .DEPTH(HALF)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (in_valid),
      .din   ((g == LANE_EVEN) ? in_even : in_odd),
      .taps  (lane_taps[g])
    );

    dwt_half_mac #(.SW(SW), .CW(CW), .OW(OW), .N(HALF)) u_mac (
      .samp (lane_taps[g]),
      .cf   (lane_cf[g]),
      .neg  ((g == LANE_EVEN) && (band == BAND_HIGH)),
      .psum (lane_sum[g])
    );
  end

  dwt_sum_stage #(.OW(OW)) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ev_sum    (lane_sum[LANE_EVEN]),
    .od_sum    (lane_sum[LANE_ODD]),
    .out_valid (out_valid),
    .out_data  (sum_out)
  );

  assign out_data = sum_out;

  // R2: a result appears two edges after a pair is taken
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  // R2: no result without a pair two edges earlier
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
endmodule

// File: tb/tb_dwt_split_filter.sv
`timescale 1ns/1ps
module tb_dwt_split_filter;
  localparam int SW   = 8;
  localparam int CW   = 8;
  localparam int TAPS = 6;
  localparam int HALF = TAPS / 2;
  localparam int OW   = SW + CW + $clog2(TAPS);
  localparam int FN   = 16;

  typedef struct packed {
    logic       v;
    logic       hp;
    logic [7:0] e;
    logic [7:0] o;
  } vec_t;

  localparam vec_t TABLE [16] = '{
    '{1'b1, 1'b0, 8'd5,   8'd3},
    '{1'b1, 1'b0, 8'hF6,  8'd12},
    '{1'b1, 1'b0, 8'd100, 8'h9C},
    '{1'b1, 1'b1, 8'd7,   8'hFE},
    '{1'b0, 1'b0, 8'd55,  8'd66},
    '{1'b1, 1'b1, 8'h80,  8'd127},
    '{1'b1, 1'b0, 8'd1,   8'd1},
    '{1'b0, 1'b1, 8'd9,   8'd9},
    '{1'b0, 1'b0, 8'd0,   8'd0},
    '{1'b1, 1'b1, 8'd42,  8'hD6},
    '{1'b1, 1'b0, 8'hE0,  8'd17},
    '{1'b1, 1'b1, 8'd0,   8'd0},
    '{1'b1, 1'b0, 8'd127, 8'h81},
    '{1'b0, 1'b0, 8'd3,   8'd4},
    '{1'b1, 1'b1, 8'hF0,  8'd33},
    '{1'b1, 1'b0, 8'd64,  8'hC0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [SW-1:0]     in_even = '0;
  logic [SW-1:0]     in_odd = '0;
  logic              hp_sel = 1'b0;
  logic [TAPS*CW-1:0] coef_flat = '0;
  logic              out_valid;
  logic [OW-1:0]     out_data;

  dwt_split_filter #(.SW(SW), .CW(CW), .TAPS(TAPS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_even(in_even),
    .in_odd(in_odd), .hp_sel(hp_sel), .coef_flat(coef_flat),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int coefs [TAPS];
  int mwe [HALF];
  int mwo [HALF];
  logic          exp1_v, exp2_v;
  logic [OW-1:0] exp1_d, exp2_d, last_d;
  string         exp1_t, exp2_t;
  int obs [64];
  int obs_n = 0;

  task automatic clear_model();
    for (int j = 0; j < HALF; j++) begin mwe[j] = 0; mwo[j] = 0; end
    exp1_v = 0; exp2_v = 0; exp1_d = '0; exp2_d = '0; last_d = '0;
    exp1_t = "R2"; exp2_t = "R2";
  endtask

  task automatic set_coefs();
    for (int i = 0; i < TAPS; i++) coef_flat[i*CW +: CW] = CW'(coefs[i]);
  endtask

  // one cycle: called at a negedge, checks then drives
  task automatic step(input logic v, input logic hp, input int e, input int o, input string tag);
    int acc;
    int ee, oo;
    checks++;
    if (out_valid) begin obs[obs_n] = int'(signed'(out_data)); obs_n++; end
    if (exp2_v) last_d = exp2_d;
    if (out_valid !== exp2_v || out_data !== last_d) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
               exp2_t, out_valid, signed'(out_data), exp2_v, signed'(last_d));
    end
    exp2_v = exp1_v; exp2_d = exp1_d; exp2_t = exp1_t;
    exp1_v = v; exp1_t = tag;
    if (v) begin
      acc = 0;
      for (int j = 0; j < HALF; j++) begin
        ee = (j == HALF-1) ? e : mwe[j];
        oo = (j == HALF-1) ? o : mwo[j];
        acc += (hp ? -1 : 1) * coefs[2*j] * ee + coefs[2*j+1] * oo;
      end
      exp1_d = OW'(acc);
      for (int j = 0; j < HALF-1; j++) begin mwe[j] = (j+1 == HALF-1) ? e : mwe[j+1]; mwo[j] = (j+1 == HALF-1) ? o : mwo[j+1]; end
    end
    set_coefs();
    in_valid = v; hp_sel = hp;
    in_even = SW'(e); in_odd = SW'(o);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1: valid=%0b data=%0d expected valid=0 data=0", out_valid, signed'(out_data));
    end
    rst_n = 1'b1;
    clear_model();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int f [FN];
    int base;
    int y;
    coefs = '{3, -5, 7, -2, 9, 4};
    clear_model();
    @(negedge clk);
    do_reset();

    // R7: first pair after reset sees zero history
    step(1'b1, 1'b0, 20, -11, "R7");
    step(1'b1, 1'b1, -3, 8, "R7");

    // table walk: R3 low band, R4 high band, R5 idle gaps
    foreach (TABLE[n]) begin
      step(TABLE[n].v, TABLE[n].hp, int'(signed'(TABLE[n].e)), int'(signed'(TABLE[n].o)),
           TABLE[n].v ? (TABLE[n].hp ? "R4" : "R3") : "R5");
    end
    step(1'b0, 1'b0, 0, 0, "R6");
    step(1'b0, 1'b0, 0, 0, "R6");
    step(1'b0, 1'b0, 0, 0, "R6");

    // R9: most negative values everywhere
    coefs = '{-128, -128, -128, -128, -128, -128};
    for (int n = 0; n < 4; n++) step(1'b1, 1'b0, -128, -128, "R9");
    step(1'b1, 1'b1, -128, -128, "R9");
    step(1'b1, 1'b0, 127, -128, "R9");
    step(1'b0, 1'b0, 0, 0, "R9");
    step(1'b0, 1'b0, 0, 0, "R9");

    // R1: reset in the middle of a stream discards in-flight results
    coefs = '{3, -5, 7, -2, 9, 4};
    step(1'b1, 1'b0, 50, 60, "R1");
    do_reset();
    step(1'b1, 1'b0, 9, -9, "R7");
    step(1'b0, 1'b0, 0, 0, "R7");
    step(1'b0, 1'b0, 0, 0, "R7");

    // R8: periodic extension of a 16-sample frame
    do_reset();
    for (int n = 0; n < FN; n++) f[n] = ((n * 37 + 11) % 200) - 100;
    base = obs_n;
    for (int m = 0; m < (FN + TAPS - 2) / 2; m++)
      step(1'b1, 1'b0, f[(2*m) % FN], f[(2*m+1) % FN], "R8");
    step(1'b0, 1'b0, 0, 0, "R8");
    step(1'b0, 1'b0, 0, 0, "R8");
    step(1'b0, 1'b0, 0, 0, "R8");
    checks++;
    if (obs_n - base != (FN + TAPS - 2) / 2) begin
      fails++;
      $display("FAIL R8: output count %0d expected %0d", obs_n - base, (FN + TAPS - 2) / 2);
    end else begin
      for (int k = 0; k < FN / 2; k++) begin
        y = 0;
        for (int i = 0; i < TAPS; i++) y += coefs[i] * f[(2*k + i) % FN];
        checks++;
        if (obs[base + HALF - 1 + k] != y) begin
          fails++;
          $display("FAIL R8: output %0d = %0d expected %0d", k, obs[base + HALF - 1 + k], y);
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule